// File: doc/BRIEF.md
# Gear-Shifted Type-II PLL Loop Filter

This block turns the phase-error samples of a digital PLL into an oscillator tuning word. The phase error first passes through four cascaded single-pole low-pass sections. Each section's coefficient is a programmable power of two, so each section uses only a shift and an add, and any section can be bypassed. The filtered error then drives two paths. The proportional path scales it by a gain that is also a power of two. The integral path accumulates it with its own power-of-two gain, which gives the loop type-II behaviour. The sum of the two paths is multiplied by an unsigned normalization factor, which stands for the reference frequency divided by the oscillator gain, and is then saturated to the tuning-word width.

To shorten lock time, the loop bandwidth can be changed ("gear-shifted") on a one-cycle strobe, and this can happen several times in one lock. At each shift the block stores a new offset in the proportional path. The offset is chosen so that the proportional term, and therefore the tuning word, does not jump when the phase error is unchanged. It is the scaled form of adding (old gain / new gain − 1) times the phase error at the switch instant. The offset stays in force until the next strobe or a reset.

Top module: `pll_loop_filter`

## Requirements
- R1: Reset is synchronous and active-low. At the first clock edge with `rst_n` low, all filter stages, the integrator, the stored offset, the active gear (cleared to 0) and `tune_word` (cleared to 0) are cleared.
- R2: Stage i (i = 0..3) takes its shift s from `lam_sh[3i+2:3i]`. At each edge it updates y <= y + ((x − y) >>> s), where >>> is an arithmetic shift that rounds toward minus infinity. Stage 0's x is `phase_err`, stage i's x is the output of stage i−1, and stage 3's output is the filtered error F.
- R3: When `stage_bypass[i]` is 1, stage i loads y <= x at the edge, whatever its shift.
- R4: The integrator updates I <= sat(I + F·2^(16−`rho_sh`)). It saturates symmetrically at ±(2^39 − 1). It holds its value while F is 0 and does not decrease while F is positive.
- R5: The proportional term is P = F·2^(16−g) + S, where g is the active gear (0..15) and S is the stored offset. The value is in fixed point with 16 fraction bits.
- R6: On an edge with `gear_load` high, g <= `gear_sh` and S <= P − F·2^(16−`gear_sh`), with P and F taken before the edge. If F does not change, P is the same before and after the shift.
- R7: While `gear_load` is low, g and S hold their values. If F does not change, P does not change.
- R8: `tune_word` is the 16-bit saturation, to [−32768, 32767], of ((P + I) · `norm_k`) >>> 24. `norm_k` is unsigned with 8 fraction bits. A `norm_k` of 0 gives a tuning word of 0.
- R9: `tune_word` is registered from the values of P and I before the edge. With all stages at shift 0, a step on `phase_err` first appears on `tune_word` after the fifth clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock (retimed reference) |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_err | input | 16 | Signed phase error sample |
| lam_sh | input | 12 | Four 3-bit per-stage shifts, stage i at bits [3i+2:3i] |
| stage_bypass | input | 4 | Per-stage bypass, bit i for stage i |
| rho_sh | input | 4 | Integral gain shift (gain 2^−rho_sh) |
| gear_load | input | 1 | One-cycle gear-change strobe |
| gear_sh | input | 4 | New proportional gain shift, taken on the strobe |
| norm_k | input | 12 | Unsigned normalization factor, 8 fraction bits |
| tune_word | output | 16 | Signed saturated oscillator tuning word |

## Verification
The assertions check on every cycle that a gear change leaves the proportional term unchanged when the filtered error is steady, and that without a strobe the term stays fixed under a steady error. They also check that the integrator holds on a zero error and never falls on a positive one, that a zero normalization factor forces a zero tuning word, and that reset clears the state. Only the bench scenarios can show the exact numbers. These include the per-stage rounding of the shift-and-add filter with mixed shifts and bypasses, the ramp of the tuning word staying exactly linear across several gear shifts, integrator and output saturation, and the five-edge latency from input to output.

// File: rtl/lf_pkg.sv
// Package: default widths shared by the loop-filter modules and the bench.
// Assumes FRAC_BITS is at least the largest gain shift (2**SHIFT_W - 1).
package lf_pkg;
    localparam int LF_PH_W     = 16;  // phase error width
    localparam int LF_NSTAGE   = 4;   // number of low-pass sections
    localparam int LF_LSH_W    = 3;   // per-section shift field width
    localparam int LF_SHIFT_W  = 4;   // gear and integral shift width
    localparam int LF_FRAC     = 16;  // fraction bits of the gain paths
    localparam int LF_ACC_W    = 40;  // width of proportional and integral terms
    localparam int LF_NORM_W   = 12;  // normalization factor width
    localparam int LF_NORM_FR  = 8;   // fraction bits of the normalization factor
    localparam int LF_OUT_W    = 16;  // tuning word width
endpackage

// File: rtl/lf_iir_stage.sv
// One single-pole low-pass section: y += (x - y) >>> sh, or y = x when bypassed.
// The coefficient is 2^-sh, so the section needs one subtract, one shift and one add.
// Assumes the result stays between y and x, so it fits in W bits.
module lf_iir_stage #(
    parameter int W    = 16,
    parameter int SH_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] x,
    input  logic [SH_W-1:0]     sh,
    input  logic                byp,
    output logic signed [W-1:0] y
);
    logic signed [W:0] diff;
    logic signed [W:0] step;

    // Difference and scaled step, one bit wider so no overflow occurs.
    always_comb begin
        diff = {x[W-1], x} - {y[W-1], y};
        step = diff >>> sh;
    end

    // Section state: cleared by reset, loaded or moved toward x.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y <= '0;
        else if (byp)
            y <= x;
        else
            y <= W'({y[W-1], y} + step);
    end
endmodule

// File: rtl/lf_iir_chain.sv
// Cascade of N low-pass sections. Section i takes its shift from sh_vec[i*SH_W +: SH_W]
// and its bypass from byp_vec[i]. The output is the last section's state.
module lf_iir_chain #(
    parameter int W    = 16,
    parameter int N    = 4,
    parameter int SH_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] x,
    input  logic [N*SH_W-1:0]   sh_vec,
    input  logic [N-1:0]        byp_vec,
    output logic signed [W-1:0] y
);
    logic signed [W-1:0] tap [0:N];

    // The chain input feeds the first tap.
    always_comb tap[0] = x;

    for (genvar i = 0; i < N; i++) begin : g_stage
        lf_iir_stage #(.W(W), .SH_W(SH_W)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .x    (tap[i]),
            .sh   (sh_vec[i*SH_W +: SH_W]),
            .byp  (byp_vec[i]),
            .y    (tap[i+1])
        );
    end

    // The last tap drives the filtered output.
    always_comb y = tap[N];
endmodule

// File: rtl/lf_gear_shift.sv
// Proportional path with hitless gain changes.
// prop = F * 2^(FRAC-gear) + offset. On a strobe, the new offset keeps prop unchanged
// for the current F, which is the gain-scaled form of adding (a_old/a_new - 1)*F.
// Assumes FRAC >= 2**SH_W - 1.
module lf_gear_shift #(
    parameter int PH_W  = 16,
    parameter int SH_W  = 4,
    parameter int FRAC  = 16,
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [PH_W-1:0]  phi_f,
    input  logic                    gear_load,
    input  logic [SH_W-1:0]         gear_sh,
    output logic signed [ACC_W-1:0] prop
);
    logic [SH_W-1:0]         gear_q;
    logic signed [ACC_W-1:0] off_q;
    logic signed [ACC_W-1:0] scaled_new;

    // Sign-extend the error and scale it by 2^(FRAC - sh).
    function automatic logic signed [ACC_W-1:0] scale(input logic signed [PH_W-1:0] v,
                                                      input logic [SH_W-1:0] sh);
        logic signed [ACC_W-1:0] ext;
        ext = ACC_W'(v);
        return ext <<< (FRAC - int'(sh));
    endfunction

    // Proportional term at the active gear, and the same error at the requested gear.
    always_comb begin
        prop       = scale(phi_f, gear_q) + off_q;
        scaled_new = scale(phi_f, gear_sh);
    end

    // Gear and offset registers, changed only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gear_q <= '0;
            off_q  <= '0;
        end else if (gear_load) begin
            gear_q <= gear_sh;
            off_q  <= prop - scaled_new;
        end
    end
endmodule

// File: rtl/lf_integrator.sv
// Integral path: acc += F * 2^(FRAC - rho_sh), saturating at +/-(2^(ACC_W-1) - 1).
// Assumes FRAC >= 2**SH_W - 1.
module lf_integrator #(
    parameter int PH_W  = 16,
    parameter int SH_W  = 4,
    parameter int FRAC  = 16,
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [PH_W-1:0]  phi_f,
    input  logic [SH_W-1:0]         rho_sh,
    output logic signed [ACC_W-1:0] integ
);
    localparam logic signed [ACC_W:0] IMAX = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] IMIN = {2'b11, {(ACC_W-2){1'b0}}, 1'b1};

    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] inc;
    logic signed [ACC_W:0]   sum;

    // Scaled increment and a sum one bit wider, used for the saturation test.
    always_comb begin
        ext = ACC_W'(phi_f);
        inc = ext <<< (FRAC - int'(rho_sh));
        sum = {integ[ACC_W-1], integ} + {inc[ACC_W-1], inc};
    end

    // Saturating accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            integ <= '0;
        else if (sum > IMAX)
            integ <= IMAX[ACC_W-1:0];
        else if (sum < IMIN)
            integ <= IMIN[ACC_W-1:0];
        else
            integ <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/pll_loop_filter.sv
// Type-II loop filter: four-section low-pass prefilter, a gear-shifted proportional path,
// an integral path, and normalization with saturation to the tuning word.
// Assumes FRAC >= 2**SHIFT_W - 1. The output is registered, one edge after the filtered error.
module pll_loop_filter
    import lf_pkg::*;
#(
    parameter int PH_W    = LF_PH_W,
    parameter int NSTAGE  = LF_NSTAGE,
    parameter int LSH_W   = LF_LSH_W,
    parameter int SHIFT_W = LF_SHIFT_W,
    parameter int FRAC    = LF_FRAC,
    parameter int ACC_W   = LF_ACC_W,
    parameter int NORM_W  = LF_NORM_W,
    parameter int NORM_FR = LF_NORM_FR,
    parameter int OUT_W   = LF_OUT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [PH_W-1:0]     phase_err,
    input  logic [NSTAGE*LSH_W-1:0]    lam_sh,
    input  logic [NSTAGE-1:0]          stage_bypass,
    input  logic [SHIFT_W-1:0]         rho_sh,
    input  logic                       gear_load,
    input  logic [SHIFT_W-1:0]         gear_sh,
    input  logic [NORM_W-1:0]          norm_k,
    output logic signed [OUT_W-1:0]    tune_word
);
    localparam int PW = ACC_W + NORM_W + 2;
    localparam int OSHIFT = FRAC + NORM_FR;
    localparam logic signed [PW-1:0] OMAX = {{(PW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [PW-1:0] OMIN = {{(PW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [PH_W-1:0]   phi_f;
    logic signed [ACC_W-1:0]  prop;
    logic signed [ACC_W-1:0]  integ;
    logic signed [ACC_W:0]    total;
    logic signed [NORM_W:0]   norm_s;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     shifted;

    lf_iir_chain #(.W(PH_W), .N(NSTAGE), .SH_W(LSH_W)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .x      (phase_err),
        .sh_vec (lam_sh),
        .byp_vec(stage_bypass),
        .y      (phi_f)
    );

    lf_gear_shift #(.PH_W(PH_W), .SH_W(SHIFT_W), .FRAC(FRAC), .ACC_W(ACC_W)) u_gear (
        .clk      (clk),
        .rst_n    (rst_n),
        .phi_f    (phi_f),
        .gear_load(gear_load),
        .gear_sh  (gear_sh),
        .prop     (prop)
    );

    lf_integrator #(.PH_W(PH_W), .SH_W(SHIFT_W), .FRAC(FRAC), .ACC_W(ACC_W)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .phi_f (phi_f),
        .rho_sh(rho_sh),
        .integ (integ)
    );

    // Sum of the two paths, normalization product and removal of the fraction bits.
    always_comb begin
        total   = {prop[ACC_W-1], prop} + {integ[ACC_W-1], integ};
        norm_s  = {1'b0, norm_k};
        prod    = PW'(total) * PW'(norm_s);
        shifted = prod >>> OSHIFT;
    end

    // Registered, saturated tuning word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tune_word <= '0;
        else if (shifted > OMAX)
            tune_word <= OMAX[OUT_W-1:0];
        else if (shifted < OMIN)
            tune_word <= OMIN[OUT_W-1:0];
        else
            tune_word <= shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/lf_checker.sv
// Checker for pll_loop_filter. It watches the filtered error, the proportional and integral
// terms, the normalization input and the tuning word. It is attached by bind.
module lf_checker #(
    parameter int PH_W   = 16,
    parameter int ACC_W  = 40,
    parameter int NORM_W = 12,
    parameter int OUT_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    gear_load,
    input logic signed [PH_W-1:0]  phi_f,
    input logic signed [ACC_W-1:0] prop,
    input logic signed [ACC_W-1:0] integ,
    input logic [NORM_W-1:0]       norm_k,
    input logic signed [OUT_W-1:0] tune_word
);
    // R1: the cycle after a reset edge shows cleared state.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (integ == 0 && prop == 0 && tune_word == 0));

    // R6: a gear change under a steady filtered error leaves the proportional term unchanged.
    p_hitless_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(gear_load) && $stable(phi_f)) |-> $stable(prop));

    // R7: without a strobe, a steady error keeps the proportional term fixed.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(gear_load) && $stable(phi_f)) |-> $stable(prop));

    // R4: a zero error leaves the integrator unchanged.
    p_integ_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phi_f) == 0) |-> $stable(integ));

    // R4: a positive error never lowers the integrator.
    p_integ_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phi_f) > 0) |-> (integ >= $past(integ)));

    // R8: a zero normalization factor yields a zero tuning word.
    p_zero_gain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(norm_k) == 0) |-> (tune_word == 0));
endmodule

bind pll_loop_filter lf_checker #(
    .PH_W  (PH_W),
    .ACC_W (ACC_W),
    .NORM_W(NORM_W),
    .OUT_W (OUT_W)
) u_lf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .gear_load(gear_load),
    .phi_f    (phi_f),
    .prop     (prop),
    .integ    (integ),
    .norm_k   (norm_k),
    .tune_word(tune_word)
);

// File: tb/pll_loop_filter_tb.sv
// Bench for pll_loop_filter. It combines seeded random stimulus with directed corner cases.
// A cycle model built from the requirements supplies the expected tuning word.
module pll_loop_filter_tb;
    localparam int PH_W = 16;
    localparam int FRAC = 16;
    localparam int OSH  = 24;

    logic              clk = 1'b0;
    logic              rst_n;
    logic signed [15:0] phase_err;
    logic [11:0]       lam_sh;
    logic [3:0]        stage_bypass;
    logic [3:0]        rho_sh;
    logic              gear_load;
    logic [3:0]        gear_sh;
    logic [11:0]       norm_k;
    logic signed [15:0] tune_word;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pll_loop_filter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_err   (phase_err),
        .lam_sh      (lam_sh),
        .stage_bypass(stage_bypass),
        .rho_sh      (rho_sh),
        .gear_load   (gear_load),
        .gear_sh     (gear_sh),
        .norm_k      (norm_k),
        .tune_word   (tune_word)
    );

    // Model state (R1..R9)
    longint my [4];
    longint ma, ms, mi, mt;
    longint phf, pp, tot, pr, xin, shv;
    localparam longint IMAXV = (64'sd1 <<< 39) - 1;

    function automatic longint sat(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Cycle model, evaluated at each rising edge with the inputs driven at the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) my[i] = 0;
            ma = 0; ms = 0; mi = 0; mt = 0;
        end else begin
            phf = my[3];
            pp  = (phf <<< (FRAC - ma)) + ms;
            tot = pp + mi;
            pr  = (tot * longint'(norm_k)) >>> OSH;
            mt  = sat(pr, -32768, 32767);
            mi  = sat(mi + (phf <<< (FRAC - longint'(rho_sh))), -IMAXV, IMAXV);
            if (gear_load) begin
                ms = pp - (phf <<< (FRAC - longint'(gear_sh)));
                ma = longint'(gear_sh);
            end
            for (int i = 3; i >= 0; i--) begin
                xin = (i == 0) ? longint'(phase_err) : my[i-1];
                shv = longint'((lam_sh >> (3*i)) & 12'd7);
                if (stage_bypass[i]) my[i] = xin;
                else my[i] = my[i] + ((xin - my[i]) >>> shv);
            end
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(string tag);
        @(negedge clk);
        chk(tag, longint'(tune_word), mt);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        gear_load = 1'b0;
        @(negedge clk);
        chk("R1 reset", longint'(tune_word), 0);
        rst_n = 1'b1;
    endtask

    task automatic rand_phase(int amp);
        phase_err = 16'($signed($urandom_range(2*amp)) - amp);
    endtask

    initial begin
        int last;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; phase_err = '0; lam_sh = '0; stage_bypass = '0;
        rho_sh = 4'd15; gear_load = 1'b0; gear_sh = '0; norm_k = 12'd256;
        repeat (3) @(negedge clk);
        chk("R1 reset", longint'(tune_word), 0);
        rst_n = 1'b1;

        // R9: step latency with all shifts 0, gear 0, norm 1.0
        phase_err = 16'sd1000;
        repeat (4) cyc("R9 before");
        @(negedge clk);
        chk("R9 latency", longint'(tune_word), 1000);

        // R3: all stages bypassed with nonzero shifts
        do_reset();
        stage_bypass = 4'hF; lam_sh = 12'hFFF; phase_err = 16'sd100;
        repeat (12) cyc("R3 bypass");
        for (int k = 0; k < 40; k++) begin
            stage_bypass = 4'($urandom_range(15));
            rand_phase(3000);
            cyc("R3 mixed");
        end

        // R2 R5: random shifts, no bypass, fixed gear
        do_reset();
        stage_bypass = '0; rho_sh = 4'd12;
        for (int i = 0; i < 4; i++) lam_sh[i*3 +: 3] = 3'($urandom_range(7));
        for (int k = 0; k < 240; k++) begin
            if (k % 8 == 0) rand_phase(2000);
            cyc("R2 R5 filter");
        end

        // R6: exact ramp across several gear shifts (delta stays 64 per cycle)
        do_reset();
        lam_sh = '0; stage_bypass = '0; rho_sh = 4'd0; norm_k = 12'd256;
        phase_err = 16'sd64;
        repeat (7) cyc("R6 settle");
        last = int'(tune_word);
        for (int g = 0; g < 4; g++) begin
            gear_load = 1'b1;
            gear_sh = (g == 0) ? 4'd2 : (g == 1) ? 4'd5 : (g == 2) ? 4'd1 : 4'd6;
            @(negedge clk);
            gear_load = 1'b0;
            chk("R6 hitless", longint'(tune_word) - last, 64);
            last = int'(tune_word);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk("R6 ramp", longint'(tune_word) - last, 64);
                chk("R6 model", longint'(tune_word), mt);
                last = int'(tune_word);
            end
        end

        // R7: offset held between random gear strobes under changing error
        do_reset();
        for (int i = 0; i < 4; i++) lam_sh[i*3 +: 3] = 3'($urandom_range(4));
        for (int k = 0; k < 400; k++) begin
            if (k % 20 == 0) begin
                rho_sh = 4'($urandom_range(15, 8));
                norm_k = 12'($urandom_range(600, 16));
            end
            if (k % 6 == 0) rand_phase(1500);
            gear_load = ($urandom_range(15) == 0);
            gear_sh = 4'($urandom_range(15));
            cyc("R7 gear");
        end
        gear_load = 1'b0;

        // R4: integrator saturation; tune holds once saturated
        do_reset();
        lam_sh = '0; rho_sh = 4'd0; gear_sh = 4'd15; gear_load = 1'b1;
        norm_k = 12'd1; phase_err = 16'sd32767;
        cyc("R4 gear");
        gear_load = 1'b0;
        repeat (300) cyc("R4 integ");
        last = int'(tune_word);
        repeat (4) begin
            @(negedge clk);
            chk("R4 saturated hold", longint'(tune_word), last);
        end

        // R8: output saturation both ways and zero gain
        do_reset();
        norm_k = 12'd4095; rho_sh = 4'd15; phase_err = 16'sd30000;
        repeat (8) cyc("R8 model");
        chk("R8 sat high", longint'(tune_word), 32767);
        do_reset();
        phase_err = -16'sd30000;
        repeat (8) cyc("R8 model");
        chk("R8 sat low", longint'(tune_word), -32768);
        norm_k = 12'd0;
        repeat (2) @(negedge clk);
        chk("R8 zero gain", longint'(tune_word), 0);

        // R1: reset mid-run clears offset and integrator
        norm_k = 12'd256; phase_err = 16'sd10;
        do_reset();
        phase_err = '0;
        repeat (6) cyc("R1 cleared");
        chk("R1 cleared out", longint'(tune_word), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule